// File: doc/BRIEF.md
# Exception Entry Bus Sequencer

This block runs the bus cycles an 8-bit processor core needs to leave normal execution. It covers a software break, a hardware interrupt (maskable or non-maskable), a reset, a power-on and the lock-up that follows an illegal halting opcode. The core gives it a one-cycle start pulse with an entry kind, and the current program counter, stack pointer and status byte. The block then owns the address, direction and write-data lines for a fixed number of cycles. When the new program counter has been fetched from the vector table, it gives the core back an updated program counter, stack pointer and status byte together with a one-cycle completion pulse.

Every entry kind has an exact, cycle-by-cycle bus pattern. A hardware interrupt or a reset begins with two throwaway reads at the program counter. Break and interrupt save three bytes on the stack page. Reset and power-on perform three stack-page reads in their place and never write. Whether a hardware interrupt is serviced as non-maskable is settled only once its status byte has been saved. The halting kind ends in a state that reads the top byte of memory forever, and only a reset-class start leaves it.

Top module: `entry_sequencer`

## Requirements
- R1: After rst_n is released, busy, done, jammed, poll and por_ack are 0 and rw is 1 (read).
- R2: A start of kind 0 (break) stores pc_in+1 and then writes, in three consecutive cycles, its high byte, its low byte and status_in with bit 4 set. The first write is in the cycle after start.
- R3: A start of kind 1 (hardware interrupt) reads twice at pc_in, then writes the program counter high byte, its low byte and status_in with bit 4 cleared.
- R4: For kind 1, nmi_pend as sampled at the end of the status-write cycle chooses the vector: 0xFFFA/0xFFFB when high, otherwise 0xFFFE/0xFFFF. Break always uses 0xFFFE/0xFFFF.
- R5: Kinds 2 (reset) and 3 (power-on) read twice at pc_in and then read three times from the stack page with the stack pointer dropping each time. They make no write and fetch the vector from 0xFFFC/0xFFFD.
- R6: Every completed entry sets status bit 2 (interrupt disable). Bit 3 (decimal) is cleared only by reset or power-on with cmos_mode=1, and is otherwise kept.
- R7: por_ack is high for exactly the first cycle of a power-on sequence and never for other kinds.
- R8: poll is high exactly in the cycle that reads the vector low byte.
- R9: done is a one-cycle pulse in the cycle after the vector-high read. In that cycle busy is 0, pc_out equals {high byte, low byte} read from the vector, and sp_out is sp_in minus 3.
- R10: Kind 4 (jam) reads 0xFFFF, 0xFFFE and 0xFFFE and then holds jammed=1 while reading 0xFFFF every cycle.
- R11: A start while a sequence runs is ignored. A start with kind 5 to 7 is ignored in idle. In the jammed state only kinds 2 and 3 are taken; they run the full reset sequence.
- R12: Each stack access addresses {0x01, sp}. The stack pointer wraps modulo 256, so it goes 0x01, 0x00, 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin an entry |
| kind_in | input | 3 | Entry kind: 0 break, 1 hardware interrupt, 2 reset, 3 power-on, 4 jam |
| pc_in | input | 16 | Program counter at the time of the request |
| sp_in | input | 8 | Stack pointer at the time of the request |
| status_in | input | 8 | Status byte at the time of the request |
| nmi_pend | input | 1 | Non-maskable request pending |
| cmos_mode | input | 1 | Selects the later core variant (decimal cleared on reset) |
| data_in | input | 8 | Read data from the bus |
| addr | output | 16 | Bus address |
| rw | output | 1 | 1 = read, 0 = write |
| data_out | output | 8 | Write data (0 on reads) |
| busy | output | 1 | A sequence or the jammed state is active |
| done | output | 1 | Entry finished; outputs hold the new state |
| jammed | output | 1 | Halted after a jam entry |
| poll | output | 1 | Cycle in which the core samples interrupt lines |
| por_ack | output | 1 | Clears the pending power-on request |
| pc_out | output | 16 | Updated program counter |
| sp_out | output | 8 | Updated stack pointer |
| status_out | output | 8 | Updated status byte |

## Verification
The bench raises the non-maskable line only after a hardware interrupt has begun. A design that settled the vector at start would then fetch from 0xFFFE instead of 0xFFFA. A break taken at pc 0x12FF checks the carry into the saved high byte, and a stack pointer of 0x01 checks the wrap to 0xFF, which a design with a wider or unwrapped pointer would write off the stack page. The bench compares a reset and a power-on, each with and without the variant flag, to catch a decimal bit cleared for the wrong variant or a power-on acknowledge on plain reset. Starts aimed at a running sequence and at the jammed state test that neither the bus pattern nor the halt is disturbed.

// File: rtl/entry_seq_pkg.sv
// Shared types for the exception entry sequencer.
// Assumes an 8-bit data path and a 16-bit address space.
package entry_seq_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned KIND_W = 3;

    // Status bit positions written onto the stack and updated on entry.
    localparam int unsigned BIT_IDIS = 2;
    localparam int unsigned BIT_DEC  = 3;
    localparam int unsigned BIT_BRK  = 4;

    typedef enum logic [KIND_W-1:0] {
        K_BRK   = 3'd0,
        K_HWINT = 3'd1,
        K_RESET = 3'd2,
        K_POWER = 3'd3,
        K_JAM   = 3'd4
    } entry_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DUMMY1,
        ST_DUMMY2,
        ST_PUSH_H,
        ST_PUSH_L,
        ST_PUSH_P,
        ST_SREAD1,
        ST_SREAD2,
        ST_SREAD3,
        ST_VEC_L,
        ST_VEC_H,
        ST_JAM1,
        ST_JAM2,
        ST_JAM3,
        ST_HALT
    } seq_state_e;

    function automatic logic is_reset_kind(input logic [KIND_W-1:0] k);
        return (k == K_RESET) || (k == K_POWER);
    endfunction

    function automatic logic is_valid_kind(input logic [KIND_W-1:0] k);
        return k <= K_JAM;
    endfunction

endpackage

// File: rtl/entry_seq_ctrl.sv
// Sequencing state machine: accepts a start, steps one bus cycle per state
// and records the entry kind and the non-maskable decision.
// Assumes start is a single-cycle pulse; starts while running are dropped.
module entry_seq_ctrl
    import entry_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [KIND_W-1:0]  kind_in,
    input  logic               nmi_pend,
    output seq_state_e         state,
    output entry_kind_e        kind_q,
    output logic               nmi_q,
    output logic               accept,
    output logic               done_q
);

    seq_state_e state_nxt;

    // Start acceptance: idle takes any valid kind, halt only reset kinds.
    always_comb begin
        accept = 1'b0;
        if (start) begin
            if (state == ST_IDLE)
                accept = is_valid_kind(kind_in);
            else if (state == ST_HALT)
                accept = is_reset_kind(kind_in);
        end
    end

    // Next-state selection, one bus cycle per state.
    always_comb begin
        state_nxt = state;
        case (state)
            ST_IDLE, ST_HALT: begin
                if (accept) begin
                    case (kind_in)
                        K_BRK:   state_nxt = ST_PUSH_H;
                        K_JAM:   state_nxt = ST_JAM1;
                        default: state_nxt = ST_DUMMY1;
                    endcase
                end
            end
            ST_DUMMY1: state_nxt = ST_DUMMY2;
            ST_DUMMY2: state_nxt = is_reset_kind(kind_q) ? ST_SREAD1 : ST_PUSH_H;
            ST_PUSH_H: state_nxt = ST_PUSH_L;
            ST_PUSH_L: state_nxt = ST_PUSH_P;
            ST_PUSH_P: state_nxt = ST_VEC_L;
            ST_SREAD1: state_nxt = ST_SREAD2;
            ST_SREAD2: state_nxt = ST_SREAD3;
            ST_SREAD3: state_nxt = ST_VEC_L;
            ST_VEC_L:  state_nxt = ST_VEC_H;
            ST_VEC_H:  state_nxt = ST_IDLE;
            ST_JAM1:   state_nxt = ST_JAM2;
            ST_JAM2:   state_nxt = ST_JAM3;
            ST_JAM3:   state_nxt = ST_HALT;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // State, kind and vector-choice registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            kind_q <= K_BRK;
            nmi_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            state  <= state_nxt;
            done_q <= (state == ST_VEC_H);
            if (accept) begin
                kind_q <= entry_kind_e'(kind_in);
                nmi_q  <= 1'b0;
            end else if (state == ST_PUSH_P) begin
                nmi_q <= (kind_q == K_HWINT) && nmi_pend;
            end
        end
    end

endmodule

// File: rtl/entry_seq_regs.sv
// Architectural copies of PC, stack pointer and status during an entry.
// Assumes data_in is valid in the vector read cycles.
module entry_seq_regs
    import entry_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic [KIND_W-1:0]  kind_in,
    input  logic [ADDR_W-1:0]  pc_in,
    input  logic [DATA_W-1:0]  sp_in,
    input  logic [DATA_W-1:0]  status_in,
    input  logic               cmos_mode,
    input  logic [DATA_W-1:0]  data_in,
    input  seq_state_e         state,
    input  entry_kind_e        kind_q,
    output logic [ADDR_W-1:0]  pc_q,
    output logic [DATA_W-1:0]  sp_q,
    output logic [DATA_W-1:0]  p_q
);

    localparam int unsigned HALF = ADDR_W / 2;

    logic stack_step;

    // Every push and every reset stack read moves the pointer down.
    always_comb begin
        stack_step = (state == ST_PUSH_H) || (state == ST_PUSH_L) ||
                     (state == ST_PUSH_P) || (state == ST_SREAD1) ||
                     (state == ST_SREAD2) || (state == ST_SREAD3);
    end

    // Load on accept, then update from the stack steps and vector reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            sp_q <= '0;
            p_q  <= '0;
        end else if (accept) begin
            pc_q <= pc_in + ((kind_in == K_BRK) ? ADDR_W'(1) : ADDR_W'(0));
            sp_q <= sp_in;
            p_q  <= status_in;
        end else begin
            if (stack_step)
                sp_q <= sp_q - DATA_W'(1);
            if (state == ST_VEC_L) begin
                pc_q[HALF-1:0]  <= data_in;
                p_q[BIT_IDIS]   <= 1'b1;
                if (is_reset_kind(kind_q) && cmos_mode)
                    p_q[BIT_DEC] <= 1'b0;
            end
            if (state == ST_VEC_H)
                pc_q[ADDR_W-1:HALF] <= data_in;
        end
    end

endmodule

// File: rtl/entry_seq_bus.sv
// Bus driver: turns the current state into address, direction and data,
// and picks the vector pair for the entry kind.
// Assumes vector bases are even so the high byte sits at base+1.
module entry_seq_bus
    import entry_seq_pkg::*;
#(
    parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
    parameter logic [ADDR_W-1:0] NMI_VEC    = 16'hFFFA,
    parameter logic [ADDR_W-1:0] RST_VEC    = 16'hFFFC,
    parameter logic [ADDR_W-1:0] IRQ_VEC    = 16'hFFFE
) (
    input  seq_state_e         state,
    input  entry_kind_e        kind_q,
    input  logic               nmi_q,
    input  logic [ADDR_W-1:0]  pc_q,
    input  logic [DATA_W-1:0]  sp_q,
    input  logic [DATA_W-1:0]  p_q,
    output logic [ADDR_W-1:0]  addr,
    output logic               rw,
    output logic [DATA_W-1:0]  data_out,
    output logic               busy,
    output logic               jammed,
    output logic               poll,
    output logic               por_ack
);

    localparam int unsigned HALF = ADDR_W / 2;

    logic [ADDR_W-1:0] vec_base;
    logic [ADDR_W-1:0] stack_addr;
    logic [ADDR_W-1:0] halt_addr;

    // Vector base: reset kinds first, then the latched non-maskable choice.
    always_comb begin
        if (is_reset_kind(kind_q))
            vec_base = RST_VEC;
        else if (nmi_q)
            vec_base = NMI_VEC;
        else
            vec_base = IRQ_VEC;
        stack_addr = {STACK_PAGE, sp_q};
        halt_addr  = IRQ_VEC | ADDR_W'(1);
    end

    // Bus cycle contents per state.
    always_comb begin
        addr     = pc_q;
        rw       = 1'b1;
        data_out = '0;
        case (state)
            ST_DUMMY1, ST_DUMMY2: addr = pc_q;
            ST_PUSH_H: begin
                addr     = stack_addr;
                rw       = 1'b0;
                data_out = pc_q[ADDR_W-1:HALF];
            end
            ST_PUSH_L: begin
                addr     = stack_addr;
                rw       = 1'b0;
                data_out = pc_q[HALF-1:0];
            end
            ST_PUSH_P: begin
                addr     = stack_addr;
                rw       = 1'b0;
                data_out = p_q;
                data_out[BIT_BRK] = (kind_q == K_BRK);
            end
            ST_SREAD1, ST_SREAD2, ST_SREAD3: addr = stack_addr;
            ST_VEC_L: addr = vec_base;
            ST_VEC_H: addr = vec_base | ADDR_W'(1);
            ST_JAM1:  addr = halt_addr;
            ST_JAM2, ST_JAM3: addr = IRQ_VEC;
            ST_HALT:  addr = halt_addr;
            default:  addr = pc_q;
        endcase
    end

    // Status strobes seen by the core.
    always_comb begin
        busy    = (state != ST_IDLE);
        jammed  = (state == ST_HALT);
        poll    = (state == ST_VEC_L);
        por_ack = (state == ST_DUMMY1) && (kind_q == K_POWER);
    end

endmodule

// File: rtl/entry_sequencer.sv
// Top of the exception entry sequencer: break, interrupt, reset, power-on
// and jam bus sequences for an 8-bit core.
// Assumes the core holds off its own bus use while busy is high.
module entry_sequencer
    import entry_seq_pkg::*;
#(
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter logic [15:0] NMI_VEC    = 16'hFFFA,
    parameter logic [15:0] RST_VEC    = 16'hFFFC,
    parameter logic [15:0] IRQ_VEC    = 16'hFFFE
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [2:0]  kind_in,
    input  logic [15:0] pc_in,
    input  logic [7:0]  sp_in,
    input  logic [7:0]  status_in,
    input  logic        nmi_pend,
    input  logic        cmos_mode,
    input  logic [7:0]  data_in,
    output logic [15:0] addr,
    output logic        rw,
    output logic [7:0]  data_out,
    output logic        busy,
    output logic        done,
    output logic        jammed,
    output logic        poll,
    output logic        por_ack,
    output logic [15:0] pc_out,
    output logic [7:0]  sp_out,
    output logic [7:0]  status_out
);

    seq_state_e  state;
    entry_kind_e kind_q;
    logic        nmi_q;
    logic        accept;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] sp_q;
    logic [DATA_W-1:0] p_q;

    entry_seq_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .kind_in  (kind_in),
        .nmi_pend (nmi_pend),
        .state    (state),
        .kind_q   (kind_q),
        .nmi_q    (nmi_q),
        .accept   (accept),
        .done_q   (done)
    );

    entry_seq_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .kind_in   (kind_in),
        .pc_in     (pc_in),
        .sp_in     (sp_in),
        .status_in (status_in),
        .cmos_mode (cmos_mode),
        .data_in   (data_in),
        .state     (state),
        .kind_q    (kind_q),
        .pc_q      (pc_q),
        .sp_q      (sp_q),
        .p_q       (p_q)
    );

    entry_seq_bus #(
        .STACK_PAGE (STACK_PAGE),
        .NMI_VEC    (NMI_VEC),
        .RST_VEC    (RST_VEC),
        .IRQ_VEC    (IRQ_VEC)
    ) i_bus (
        .state    (state),
        .kind_q   (kind_q),
        .nmi_q    (nmi_q),
        .pc_q     (pc_q),
        .sp_q     (sp_q),
        .p_q      (p_q),
        .addr     (addr),
        .rw       (rw),
        .data_out (data_out),
        .busy     (busy),
        .jammed   (jammed),
        .poll     (poll),
        .por_ack  (por_ack)
    );

    // Architectural outputs follow the working registers.
    always_comb begin
        pc_out     = pc_q;
        sp_out     = sp_q;
        status_out = p_q;
    end

endmodule

// File: rtl/entry_seq_checker.sv
// Protocol checks on the sequencer ports, bound to every instance.
module entry_seq_checker #(
    parameter logic [7:0] STACK_PAGE = 8'h01
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] addr,
    input logic        rw,
    input logic        busy,
    input logic        done,
    input logic        jammed,
    input logic        poll,
    input logic        por_ack,
    input logic [7:0]  sp_out
);

    // Writes only ever land on the stack page.
    p_write_page_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rw |-> addr[15:8] == STACK_PAGE);

    // Each write moves the stack pointer down by one.
    p_sp_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rw |=> sp_out == $past(sp_out) - 8'd1);

    // Completion is a single-cycle pulse outside the busy window.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // The halted state reads the top byte of memory.
    p_halt_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        jammed |-> (addr == 16'hFFFF) && rw && busy);

    // The poll cycle is an even vector-table read.
    p_poll_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        poll |-> rw && (addr[15:4] == 12'hFFF) && !addr[0]);
    p_poll_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        poll |=> !poll);

    // Power-on acknowledge is one cycle and is followed by a read.
    p_ack_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        por_ack |=> !por_ack && rw);

endmodule

bind entry_sequencer entry_seq_checker #(.STACK_PAGE(STACK_PAGE)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .rw      (rw),
    .busy    (busy),
    .done    (done),
    .jammed  (jammed),
    .poll    (poll),
    .por_ack (por_ack),
    .sp_out  (sp_out)
);

// File: tb/test_entry_sequencer.sv
module test_entry_sequencer;

    typedef struct {
        logic [15:0] addr;
        logic        rw;
        logic [7:0]  dout;
        logic        poll;
        logic        por;
        string       req;
    } bus_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  kind_in = 3'd0;
    logic [15:0] pc_in = 16'h0;
    logic [7:0]  sp_in = 8'h0;
    logic [7:0]  status_in = 8'h0;
    logic        nmi_pend = 1'b0;
    logic        cmos_mode = 1'b0;
    logic [7:0]  data_in;
    logic [15:0] addr;
    logic        rw;
    logic [7:0]  data_out;
    logic        busy, done, jammed, poll, por_ack;
    logic [15:0] pc_out;
    logic [7:0]  sp_out, status_out;

    int n_checks = 0;
    int n_fails  = 0;
    bus_item_t exp_q[$];

    always #2.5 clk = ~clk;

    entry_sequencer i_entry_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .kind_in(kind_in),
        .pc_in(pc_in), .sp_in(sp_in), .status_in(status_in),
        .nmi_pend(nmi_pend), .cmos_mode(cmos_mode), .data_in(data_in),
        .addr(addr), .rw(rw), .data_out(data_out), .busy(busy), .done(done),
        .jammed(jammed), .poll(poll), .por_ack(por_ack), .pc_out(pc_out),
        .sp_out(sp_out), .status_out(status_out)
    );

    function automatic logic [7:0] mem_rd(input logic [15:0] a);
        case (a)
            16'hFFFA: return 8'h34;
            16'hFFFB: return 8'h12;
            16'hFFFC: return 8'h78;
            16'hFFFD: return 8'h56;
            16'hFFFE: return 8'hBC;
            16'hFFFF: return 8'h9A;
            default:  return 8'hEE;
        endcase
    endfunction

    always_comb data_in = mem_rd(addr);

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: compares each live bus cycle against the next expected item.
    always @(negedge clk) begin
        if (rst_n && busy && !jammed && exp_q.size() > 0) begin
            bus_item_t it;
            it = exp_q.pop_front();
            check(addr == it.addr, it.req, "addr", 32'(addr), 32'(it.addr));
            check(rw == it.rw, it.req, "rw", 32'(rw), 32'(it.rw));
            if (!it.rw)
                check(data_out == it.dout, it.req, "wdata", 32'(data_out), 32'(it.dout));
            check(poll == it.poll, "R8", "poll", 32'(poll), 32'(it.poll));
            check(por_ack == it.por, "R7", "por_ack", 32'(por_ack), 32'(it.por));
        end
    end

    function automatic bus_item_t mk(input logic [15:0] a, input logic r,
                                     input logic [7:0] d, input logic pl,
                                     input logic pr, input string req);
        bus_item_t it;
        it.addr = a; it.rw = r; it.dout = d; it.poll = pl; it.por = pr; it.req = req;
        return it;
    endfunction

    // Driver: builds the expected cycle list, fires start, checks completion.
    task automatic run_entry(input logic [2:0] k, input logic [15:0] pc,
                             input logic [7:0] sp, input logic [7:0] p,
                             input logic nmi_early, input logic nmi_late,
                             input logic cmos_v, input logic poke);
        logic [15:0] pcv;
        logic [15:0] base;
        logic [7:0]  s;
        logic [7:0]  p_exp;
        logic        rst_k;
        int          n;
        rst_k = (k == 3'd2) || (k == 3'd3);
        pcv   = (k == 3'd0) ? pc + 16'd1 : pc;
        s     = sp;
        n     = 0;
        if (k != 3'd0) begin
            exp_q.push_back(mk(pc, 1'b1, 8'h0, 1'b0, k == 3'd3, rst_k ? "R5" : "R3"));
            exp_q.push_back(mk(pc, 1'b1, 8'h0, 1'b0, 1'b0, rst_k ? "R5" : "R3"));
            n += 2;
        end
        if (!rst_k) begin
            exp_q.push_back(mk({8'h01, s}, 1'b0, pcv[15:8], 1'b0, 1'b0, "R2")); s--;
            exp_q.push_back(mk({8'h01, s}, 1'b0, pcv[7:0], 1'b0, 1'b0, "R12")); s--;
            exp_q.push_back(mk({8'h01, s}, 1'b0,
                               (k == 3'd0) ? (p | 8'h10) : (p & 8'hEF), 1'b0, 1'b0,
                               (k == 3'd0) ? "R2" : "R3")); s--;
        end else begin
            for (int i = 0; i < 3; i++) begin
                exp_q.push_back(mk({8'h01, s}, 1'b1, 8'h0, 1'b0, 1'b0, "R5"));
                s--;
            end
        end
        n += 3;
        if (rst_k)                             base = 16'hFFFC;
        else if (k == 3'd1 && (nmi_early || nmi_late)) base = 16'hFFFA;
        else                                   base = 16'hFFFE;
        exp_q.push_back(mk(base, 1'b1, 8'h0, 1'b1, 1'b0, "R4"));
        exp_q.push_back(mk(base | 16'd1, 1'b1, 8'h0, 1'b0, 1'b0, "R4"));
        n += 2;
        p_exp = p | 8'h04;
        if (rst_k && cmos_v) p_exp = p_exp & 8'hF7;

        kind_in = k; pc_in = pc; sp_in = sp; status_in = p;
        nmi_pend = nmi_early; cmos_mode = cmos_v; start = 1'b1;
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            start = poke && (i == 0);
            if (poke && i == 0) kind_in = 3'd4;  // R11: start while running
            if (nmi_late && i == 0) nmi_pend = 1'b1;
            @(negedge clk);
        end
        start = 1'b0;
        check(done == 1'b1, "R9", "done", 32'(done), 32'd1);
        check(busy == 1'b0, "R9", "busy at done", 32'(busy), 32'd0);
        check(pc_out == {mem_rd(base | 16'd1), mem_rd(base)}, "R9", "pc_out",
              32'(pc_out), 32'({mem_rd(base | 16'd1), mem_rd(base)}));
        check(sp_out == sp - 8'd3, "R12", "sp_out", 32'(sp_out), 32'(sp - 8'd3));
        check(status_out == p_exp, "R6", "status_out", 32'(status_out), 32'(p_exp));
        check(exp_q.size() == 0, "R9", "cycles left", 32'(exp_q.size()), 32'd0);
        nmi_pend = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R9", "done pulse width", 32'(done), 32'd0);
    endtask

    initial begin
        #500us;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check(busy == 1'b0 && done == 1'b0 && jammed == 1'b0, "R1", "idle flags",
              {29'd0, busy, done, jammed}, 32'd0);
        check(rw == 1'b1 && poll == 1'b0 && por_ack == 1'b0, "R1", "idle bus",
              {29'd0, rw, poll, por_ack}, 32'd4);

        run_entry(3'd0, 16'h12FF, 8'hFD, 8'h20, 1'b0, 1'b0, 1'b0, 1'b0); // R2 break, carry
        run_entry(3'd1, 16'h4000, 8'hF0, 8'h08, 1'b0, 1'b0, 1'b1, 1'b0); // R3 irq, D kept
        run_entry(3'd1, 16'h5123, 8'hE0, 8'hC3, 1'b1, 1'b0, 1'b0, 1'b0); // R4 nmi early
        run_entry(3'd1, 16'h6001, 8'h80, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0); // R4 nmi late
        run_entry(3'd2, 16'h7777, 8'h00, 8'h08, 1'b0, 1'b0, 1'b0, 1'b0); // R5 R6 no clear
        run_entry(3'd3, 16'h0200, 8'h40, 8'h0C, 1'b0, 1'b0, 1'b1, 1'b0); // R7 R6 clear
        run_entry(3'd2, 16'h0300, 8'h10, 8'h08, 1'b0, 1'b0, 1'b1, 1'b0); // R6 reset cmos
        run_entry(3'd0, 16'hABCD, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1); // R12 wrap, R11 poke

        // R11: unknown kind in idle is ignored
        kind_in = 3'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b0, "R11", "busy after kind 5", 32'(busy), 32'd0);

        // R10: jam sequence then halt
        exp_q.push_back(mk(16'hFFFF, 1'b1, 8'h0, 1'b0, 1'b0, "R10"));
        exp_q.push_back(mk(16'hFFFE, 1'b1, 8'h0, 1'b0, 1'b0, "R10"));
        exp_q.push_back(mk(16'hFFFE, 1'b1, 8'h0, 1'b0, 1'b0, "R10"));
        kind_in = 3'd4; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            check(jammed == 1'b1, "R10", "jammed", 32'(jammed), 32'd1);
            check(addr == 16'hFFFF && rw, "R10", "halt addr", 32'(addr), 32'hFFFF);
            @(negedge clk);
        end
        check(exp_q.size() == 0, "R10", "jam cycles left", 32'(exp_q.size()), 32'd0);

        // R11: a break start while halted is ignored
        kind_in = 3'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(jammed == 1'b1 && addr == 16'hFFFF, "R11", "halt kept",
              32'(addr), 32'hFFFF);

        // R11: reset leaves the halt with a full reset sequence
        run_entry(3'd2, 16'h1234, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        check(jammed == 1'b0, "R11", "jammed after reset", 32'(jammed), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule